// File: doc/BRIEF.md
# Indexed Slave Response Return Path

This block sits in the return path of a bus interconnect that links one Wishbone master to several slaves. Each time the master's strobe is accepted, the block stores the number of the slave that the address decoder picked. The acknowledge, error and read data that go back to the master are then taken from that one slave only, through a register stage.

The block does not search every slave's acknowledge in priority order. Because the responder is named by a stored index, the output logic is a balanced selector whose depth grows with the logarithm of the slave count. The decoder's choice can arrive either as a binary slave number or as a one-hot vector, and a parameter chooses the form.

Top module: `wbrm_return_mux`

## Requirements
- R1: On each rising edge where `m_stb` is high and `m_stall` is low (an accepted request), the block stores the slave chosen by `sel_in` as the responding slave index.
- R2: At any edge without an accepted request, the stored index is held. A change of `sel_in` while the strobe is low or the stall is high has no effect on which slave is routed.
- R3: `m_ack` after a rising edge equals the acknowledge, sampled at that edge, of the slave named by the index that was stored before that edge. This gives one register of latency.
- R4: `m_err` follows the error input of the stored slave with the same timing as R3.
- R5: `m_dat` follows the read data of the stored slave with the same timing as R3.
- R6: Acknowledge, error and data inputs of every slave other than the stored one have no effect on the outputs.
- R7: In binary mode (`SEL_MODE` = SEL_BINARY) the value of `sel_in` is the slave number. If the stored index is `NUM_SLV` or higher, `m_ack` and `m_err` are forced to 0 and `m_dat` to zero.
- R8: In one-hot mode (`SEL_MODE` = SEL_ONEHOT) `sel_in` is `NUM_SLV` bits wide, and bit i set selects slave i. An all-zero vector selects slave 0.
- R9: A synchronous active-high `rst` clears `m_ack`, `m_err` and `m_dat` and sets the stored index to 0.
- R10: `NUM_SLV` is a parameter of at least 2, eight by default. The index width is ceil(log2(`NUM_SLV`)): 2 bits for four slaves and 3 bits for eight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| m_stb | input | 1 | Master strobe |
| m_stall | input | 1 | Stall returned to the master; a request is accepted only when low |
| sel_in | input | SELW | Slave choice from the address decoder; binary (IW bits) or one-hot (NUM_SLV bits) |
| s_ack | input | NUM_SLV | Acknowledge from each slave |
| s_err | input | NUM_SLV | Error from each slave |
| s_dat | input | NUM_SLV*DW | Read data of all slaves; slave i at bits i*DW upward |
| m_ack | output | 1 | Registered acknowledge to the master |
| m_err | output | 1 | Registered error to the master |
| m_dat | output | DW | Registered read data to the master |

## Verification
The binary configuration uses six slaves, so that codes 6 and 7 exist without naming a slave. Each slave in turn is addressed and then answered alone. This shows whether data and acknowledge are taken from the right lane. Other slaves then drive acknowledge and error while the addressed one is silent, which separates an indexed selector from one that ORs or scans all responders. Stalled strobes and select changes without a strobe show whether the index is held, and the out-of-range codes, with every slave responding, show the forced zeros. A one-hot instance with eight slaves walks a single set bit across all positions and ends with an empty vector, with every slave acknowledging and each slave's data distinct.

// File: rtl/wbrm_pkg.sv
package wbrm_pkg;

   typedef enum logic {
      SEL_BINARY = 1'b0,
      SEL_ONEHOT = 1'b1
   } sel_mode_e;

   function automatic int idx_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/wbrm_sel_enc.sv
module wbrm_sel_enc
   import wbrm_pkg::*;
#(
   parameter int        NUM_SLV  = 8,
   parameter sel_mode_e SEL_MODE = SEL_BINARY,
   parameter int        IW       = 3,
   parameter int        SELW     = 3
)(
   input  logic [SELW-1:0] sel_i,
   output logic [IW-1:0]   idx_o
);

   if (SEL_MODE == SEL_ONEHOT) begin : g_onehot
      if (SELW != NUM_SLV) begin : g_bad_w
         $error("one-hot select must be NUM_SLV bits wide");
      end
      // Each index bit is the OR of all select lines whose slave number has that bit set.
      for (genvar b = 0; b < IW; b++) begin : g_bit
         logic [NUM_SLV-1:0] mask;
         for (genvar i = 0; i < NUM_SLV; i++) begin : g_m
            assign mask[i] = (((i >> b) & 1) != 0);
         end
         assign idx_o[b] = |(sel_i & mask);
      end
   end else begin : g_binary
      if (SELW != IW) begin : g_bad_w
         $error("binary select must be IW bits wide");
      end
      assign idx_o = sel_i;
   end

endmodule

// File: rtl/wbrm_idx_reg.sv
module wbrm_idx_reg #(
   parameter int IW = 3
)(
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [IW-1:0] idx_d,
   output logic [IW-1:0] idx_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q <= '0;
      end else if (load) begin
         idx_q <= idx_d;
      end
   end

   assert_idx_load_R1: assert property (@(posedge clk) disable iff (rst)
      load |=> (idx_q == $past(idx_d)));

   assert_idx_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(idx_q));

endmodule

// File: rtl/wbrm_resp_stage.sv
module wbrm_resp_stage #(
   parameter int NUM_SLV = 8,
   parameter int DW      = 32,
   parameter int IW      = 3
)(
   input  logic                  clk,
   input  logic                  rst,
   input  logic [IW-1:0]         idx,
   input  logic [NUM_SLV-1:0]    s_ack,
   input  logic [NUM_SLV-1:0]    s_err,
   input  logic [NUM_SLV*DW-1:0] s_dat,
   output logic                  m_ack,
   output logic                  m_err,
   output logic [DW-1:0]         m_dat
);

   localparam int DEPTH = 1 << IW;

   // Lanes padded to a power of two; codes without a slave read as silent.
   logic          ack_a [DEPTH];
   logic          err_a [DEPTH];
   logic [DW-1:0] dat_a [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_lane
      if (k < NUM_SLV) begin : g_real
         assign ack_a[k] = s_ack[k];
         assign err_a[k] = s_err[k];
         assign dat_a[k] = s_dat[k*DW +: DW];
      end else begin : g_pad
         assign ack_a[k] = 1'b0;
         assign err_a[k] = 1'b0;
         assign dat_a[k] = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         m_ack <= 1'b0;
         m_err <= 1'b0;
         m_dat <= '0;
      end else begin
         m_ack <= ack_a[idx];
         m_err <= err_a[idx];
         m_dat <= dat_a[idx];
      end
   end

   assert_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
      (int'(idx) >= NUM_SLV) |=> (!m_ack && !m_err && (m_dat == '0)));

   assert_ack_src_R3: assert property (@(posedge clk) disable iff (rst)
      m_ack |-> $past(|s_ack));

   assert_err_src_R4: assert property (@(posedge clk) disable iff (rst)
      m_err |-> $past(|s_err));

endmodule

// File: rtl/wbrm_return_mux.sv
module wbrm_return_mux
   import wbrm_pkg::*;
#(
   parameter int        NUM_SLV  = 8,
   parameter int        DW       = 32,
   parameter sel_mode_e SEL_MODE = SEL_BINARY,
   localparam int       IW       = idx_bits(NUM_SLV),
   localparam int       SELW     = (SEL_MODE == SEL_ONEHOT) ? NUM_SLV : IW
)(
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  m_stb,
   input  logic                  m_stall,
   input  logic [SELW-1:0]       sel_in,
   input  logic [NUM_SLV-1:0]    s_ack,
   input  logic [NUM_SLV-1:0]    s_err,
   input  logic [NUM_SLV*DW-1:0] s_dat,
   output logic                  m_ack,
   output logic                  m_err,
   output logic [DW-1:0]         m_dat
);

   // R10: elaboration checks on the parameters
   if (NUM_SLV < 2) begin : g_chk_n
      $error("NUM_SLV must be at least 2");
   end
   if (DW < 1) begin : g_chk_w
      $error("DW must be at least 1");
   end

   logic          accept;
   logic [IW-1:0] idx_new;
   logic [IW-1:0] idx_cur;

   assign accept = m_stb & ~m_stall;

   wbrm_sel_enc #(
      .NUM_SLV  (NUM_SLV),
      .SEL_MODE (SEL_MODE),
      .IW       (IW),
      .SELW     (SELW)
   ) u_enc (
      .sel_i (sel_in),
      .idx_o (idx_new)
   );

   wbrm_idx_reg #(
      .IW (IW)
   ) u_idx (
      .clk   (clk),
      .rst   (rst),
      .load  (accept),
      .idx_d (idx_new),
      .idx_q (idx_cur)
   );

   wbrm_resp_stage #(
      .NUM_SLV (NUM_SLV),
      .DW      (DW),
      .IW      (IW)
   ) u_resp (
      .clk   (clk),
      .rst   (rst),
      .idx   (idx_cur),
      .s_ack (s_ack),
      .s_err (s_err),
      .s_dat (s_dat),
      .m_ack (m_ack),
      .m_err (m_err),
      .m_dat (m_dat)
   );

   if (SEL_MODE == SEL_ONEHOT) begin : g_oh_chk
      assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (rst)
         accept |-> $onehot0(sel_in));
   end

endmodule

// File: tb/tb_wbrm_return_mux.sv
module tb_wbrm_return_mux;

   localparam int BN = 6;
   localparam int ON = 8;
   localparam int DW = 32;

   logic clk = 1'b0;
   always #4 clk = ~clk;  // 125 MHz

   logic rst;

   logic             b_stb, b_stall;
   logic [2:0]       b_sel;
   logic [BN-1:0]    b_ack, b_err;
   logic [BN*DW-1:0] b_dat;
   logic             b_mack, b_merr;
   logic [DW-1:0]    b_mdat;

   logic             o_stb, o_stall;
   logic [ON-1:0]    o_sel;
   logic [ON-1:0]    o_ack, o_err;
   logic [ON*DW-1:0] o_dat;
   logic             o_mack, o_merr;
   logic [DW-1:0]    o_mdat;

   wbrm_return_mux #(.NUM_SLV(BN), .DW(DW), .SEL_MODE(wbrm_pkg::SEL_BINARY)) dut (
      .clk(clk), .rst(rst), .m_stb(b_stb), .m_stall(b_stall), .sel_in(b_sel),
      .s_ack(b_ack), .s_err(b_err), .s_dat(b_dat),
      .m_ack(b_mack), .m_err(b_merr), .m_dat(b_mdat));

   wbrm_return_mux #(.NUM_SLV(ON), .DW(DW), .SEL_MODE(wbrm_pkg::SEL_ONEHOT)) dut_oh (
      .clk(clk), .rst(rst), .m_stb(o_stb), .m_stall(o_stall), .sel_in(o_sel),
      .s_ack(o_ack), .s_err(o_err), .s_dat(o_dat),
      .m_ack(o_mack), .m_err(o_merr), .m_dat(o_mdat));

   typedef struct {
      logic          ack;
      logic          err;
      logic [DW-1:0] dat;
      string         tag;
   } exp_t;

   exp_t q[$];
   int   total = 0;
   int   bad   = 0;
   int   midx  = 0;

   function automatic logic [DW-1:0] pat(input int i, input int seed);
      return {seed[15:0], 8'hA5 ^ 8'(i), 8'(i)};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: one bus cycle on the binary instance, expected result pushed to the scoreboard
   task automatic cyc(input logic stb, input logic stall, input logic [2:0] sel,
                      input logic [BN-1:0] ack, input logic [BN-1:0] err,
                      input int seed, input string tag);
      exp_t e;
      @(negedge clk);
      b_stb   = stb;
      b_stall = stall;
      b_sel   = sel;
      b_ack   = ack;
      b_err   = err;
      for (int i = 0; i < BN; i++) b_dat[i*DW +: DW] = pat(i, seed);
      e.ack = (midx < BN) ? ack[midx] : 1'b0;
      e.err = (midx < BN) ? err[midx] : 1'b0;
      e.dat = (midx < BN) ? pat(midx, seed) : '0;
      e.tag = tag;
      q.push_back(e);
      if (stb && !stall) midx = int'(sel);
   endtask

   // monitor: compares each registered result shortly after the edge that produced it
   always @(posedge clk) begin
      exp_t e;
      #2;
      if (q.size() > 0) begin
         e = q.pop_front();
         total++;
         if (b_mack !== e.ack || b_merr !== e.err || b_mdat !== e.dat) begin
            bad++;
            $display("FAIL %s: actual ack=%0b err=%0b dat=%h expected ack=%0b err=%0b dat=%h",
                     e.tag, b_mack, b_merr, b_mdat, e.ack, e.err, e.dat);
         end
      end
   end

   task automatic oh_pick(input logic [ON-1:0] sel, input int exp_slv, input string tag);
      @(negedge clk);
      o_stb = 1'b1;
      o_sel = sel;
      o_ack = '1;
      o_err = '0;
      for (int i = 0; i < ON; i++) o_dat[i*DW +: DW] = pat(i, 77);
      @(negedge clk);
      o_stb = 1'b0;
      o_sel = '0;
      @(posedge clk);
      #2;
      chk(o_mdat === pat(exp_slv, 77) && o_mack === 1'b1, tag, o_mdat, pat(exp_slv, 77));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1'b1;
      b_stb = 0; b_stall = 0; b_sel = '0; b_ack = '1; b_err = '1; b_dat = '1;
      o_stb = 0; o_stall = 0; o_sel = '0; o_ack = '1; o_err = '1; o_dat = '1;
      repeat (3) @(negedge clk);
      // R9: outputs cleared while reset is held even with all slaves responding
      chk(b_mack === 1'b0, "R9 reset ack", {31'd0, b_mack}, '0);
      chk(b_merr === 1'b0, "R9 reset err", {31'd0, b_merr}, '0);
      chk(b_mdat === '0,   "R9 reset dat", b_mdat, '0);
      b_ack = '0; b_err = '0;
      o_ack = '0; o_err = '0;
      rst = 1'b0;
      midx = 0;

      cyc(0, 0, 3'd4, 6'b000001, 6'b000000, 10, "R9 index zero after reset");
      cyc(1, 0, 3'd3, 6'b000000, 6'b000000, 11, "R1 accept slave 3");
      cyc(0, 0, 3'd0, 6'b100010, 6'b000000, 12, "R6 other slaves ack");
      cyc(0, 0, 3'd0, 6'b001000, 6'b000000, 13, "R3 R5 ack from slave 3");
      cyc(1, 1, 3'd1, 6'b001010, 6'b000000, 14, "R2 stalled request ignored");
      cyc(0, 0, 3'd2, 6'b001000, 6'b000000, 15, "R2 select without strobe");
      cyc(0, 0, 3'd0, 6'b000000, 6'b001000, 16, "R4 err from slave 3");
      cyc(0, 0, 3'd0, 6'b000000, 6'b110111, 17, "R6 other slaves err");

      for (int s = 0; s < BN; s++) begin
         cyc(1, 0, 3'(s), 6'b000000, 6'b000000, 20 + s, "R1 accept in sweep");
         cyc(0, 0, 3'd0, 6'(1 << s), 6'b000000, 30 + s, "R3 R5 sweep response");
         cyc(0, 0, 3'd0, ~6'(1 << s), ~6'(1 << s), 40 + s, "R6 sweep others");
      end

      cyc(1, 0, 3'd6, 6'b000000, 6'b000000, 50, "R7 accept code 6");
      cyc(0, 0, 3'd0, 6'b111111, 6'b111111, 51, "R7 code 6 forced zero");
      cyc(1, 0, 3'd7, 6'b111111, 6'b111111, 52, "R7 accept code 7");
      cyc(0, 0, 3'd0, 6'b111111, 6'b111111, 53, "R7 code 7 forced zero");
      cyc(1, 0, 3'd0, 6'b111111, 6'b111111, 54, "R7 leave range");
      cyc(0, 0, 3'd0, 6'b000001, 6'b000000, 55, "R7 back in range");
      cyc(0, 0, 3'd0, 6'b000000, 6'b000000, 56, "R3 idle");

      repeat (3) @(negedge clk);
      chk(q.size() == 0, "R3 scoreboard drained", DW'(q.size()), '0);

      for (int i = 0; i < ON; i++) begin
         oh_pick(8'(1 << i), i, "R8 one-hot bit");
      end
      oh_pick(8'h00, 0, "R8 empty select picks slave 0");
      oh_pick(8'h40, 6, "R10 eight slaves index 6");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule